// File: doc/BRIEF.md
# Read-Only NAND Flash Bus Responder

This block is the device end of a small NAND-style flash that can only be read. It watches a byte-wide bus with two active-low chip enables, a command latch enable, an address latch enable, a write strobe and a read strobe. A host issues a read-mode command, supplies three address bytes, and then pulses the read strobe. Each pulse returns one byte and moves the device to the next address. The array is laid out as pages of 528 bytes, with 32 pages in each block.

Two banks sit behind the bus. Each bank has its own mode, address pointer, error flag, ready flag and contents. Each bank's contents are a parameterized image that is computed, not stored. The first four bytes of block 0 carry a little-endian count of the image blocks. The image blocks follow block 0 and hold a fixed data pattern. Every other byte reads as erased.

The strobes are brought into the system clock domain, and each bus cycle is taken on the falling edge of its strobe. Programming, erasing and busy timing are not part of this block.

Top module: `nand_rd_responder`

## Requirements
- R1: A command byte is acted on as follows. 0xFF returns the bank to its idle mode. 0x00, 0x01 and 0x50 select read modes A, B and C, and each of these three restarts the address-byte count at zero.
- R2: The first address byte after a read-mode command sets the pointer to that byte plus a column base. The base is 0 in mode A, 0x100 in mode B and 0x200 in mode C.
- R3: The second address byte adds byte×135168 (528×256) to the pointer, and the third address byte adds byte×528.
- R4: Three things are illegal: a command byte other than 0xFF, 0x00, 0x01 or 0x50, an address byte while the bank is idle, and a fourth address byte. Each one sets that bank's error bit (bit 0 for bank 0, bit 1 for bank 1). The mode and pointer stay as they were, and the error bit stays set until reset.
- R5: A command or address byte is taken on a falling write strobe. If command latch is high, the byte is a command even when address latch is also high. If only address latch is high, the byte is an address.
- R6: A falling read strobe with both latch enables low loads `bus_out` with the byte at the bank's pointer and raises `bus_oe`. It then advances the pointer by one. Reads work in every mode. The result is visible after the third rising clock edge, counting from the edge that first sees the strobe low.
- R7: A low `ce0_n` selects bank 0 and wins over `ce1_n`. A low `ce1_n` alone selects bank 1. With both enables high the bus has no effect, and bus activity never touches the bank that is not selected.
- R8: While a bank is selected and both strobes are high, `bus_oe` drops and that bank's ready bit is set. Ready bits are never cleared except by reset.
- R9: Bytes 0 to 3 hold the image block count, least significant byte first. Addresses from 16896 up to 16896×(count+1) read (addr[7:0] XOR addr[15:8]), and bank 1 further XORs that value with 0xA5. Addresses at or above DEPTH, and every other address, read 0xFF.
- R10: The pointer saturates at 2^ADDR_W−1, both while address bytes are being combined and when a read advances it.
- R11: After reset both banks are idle with pointer zero, and `bus_oe`, `ready` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Byte driven by the host |
| ce0_n | input | 1 | Bank 0 enable, active low, priority |
| ce1_n | input | 1 | Bank 1 enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| bus_out | output | 8 | Byte returned by the last read |
| bus_oe | output | 1 | High while the device drives `bus_out` |
| ready | output | 2 | Per-bank ready flags |
| err | output | 2 | Per-bank sticky error flags |

## Verification
The assertions check these rules on every cycle:
- Every read event turns on the output, and every idle cycle turns it off.
- Error and ready bits never fall.
- With no chip enable low, the output stays still.
- At most one bank sees an event in a cycle.
- The pointer either steps by one or holds at its ceiling.

The column bases, the row and page weights, command priority, the image contents and the error cases all depend on particular byte sequences. Only the bench scenarios can show these, with hand-computed bytes that the bench compares against a behavioural model on every clock.

// File: rtl/nand_rd_pkg.sv
`timescale 1ns/1ps
package nand_rd_pkg;
  localparam int unsigned PAGE_BYTES     = 528;
  localparam int unsigned BLOCK_PAGES    = 32;
  localparam int unsigned BLOCK_BYTES    = PAGE_BYTES * BLOCK_PAGES;
  localparam int unsigned ROW_HI_STRIDE  = PAGE_BYTES * 256;
  localparam logic [7:0]  ERASED_BYTE    = 8'hFF;
  localparam logic [7:0]  BANK1_MARK     = 8'hA5;

  localparam logic [7:0]  OP_IDLE        = 8'hFF;
  localparam logic [7:0]  OP_MODE_A      = 8'h00;
  localparam logic [7:0]  OP_MODE_B      = 8'h01;
  localparam logic [7:0]  OP_MODE_C      = 8'h50;

  typedef enum logic [1:0] {ST_IDLE, ST_MODE_A, ST_MODE_B, ST_MODE_C} bank_mode_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ce0_n;
    logic       ce1_n;
    logic       cle;
    logic       ale;
    logic       we_n;
    logic       re_n;
  } bus_snap_t;

  localparam bus_snap_t BUS_QUIET = '{data: 8'h00, ce0_n: 1'b1, ce1_n: 1'b1,
                                      cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1};

  // Column base for the first address byte, chosen by the read mode.
  function automatic logic [9:0] column_base(bank_mode_e mode, logic [7:0] b);
    case (mode)
      ST_MODE_B: return {2'b01, b};
      ST_MODE_C: return {2'b10, b};
      default:   return {2'b00, b};
    endcase
  endfunction

  // Addition clipped to a ceiling.
  function automatic logic [63:0] sat_add(logic [63:0] a, logic [63:0] inc, logic [63:0] lim);
    logic [63:0] s;
    s = a + inc;
    if (s > lim || s < a) return lim;
    return s;
  endfunction

  // Generated array contents for one bank.
  function automatic logic [7:0] image_byte(logic [63:0] a, logic bank1,
                                            logic [63:0] depth, logic [31:0] blocks);
    logic [63:0] img_end;
    img_end = 64'(BLOCK_BYTES) * (64'(blocks) + 64'd1);
    if (a >= depth) return ERASED_BYTE;
    if (a < 64'd4) return blocks[8*a[1:0] +: 8];
    if (a >= 64'(BLOCK_BYTES) && a < img_end)
      return a[7:0] ^ a[15:8] ^ (bank1 ? BANK1_MARK : 8'h00);
    return ERASED_BYTE;
  endfunction
endpackage

// File: rtl/nand_rd_sampler.sv
`timescale 1ns/1ps
module nand_rd_sampler
  import nand_rd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bus_snap_t bus_raw,
  output bus_snap_t bus_smp,
  output logic      we_fall,
  output logic      re_fall
);
  bus_snap_t pipe_q [SYNC_STAGES];
  logic      we_prev_q;
  logic      re_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= BUS_QUIET;
    else        pipe_q[0] <= bus_raw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= BUS_QUIET;
      else        pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      re_prev_q <= 1'b1;
    end else begin
      we_prev_q <= pipe_q[SYNC_STAGES-1].we_n;
      re_prev_q <= pipe_q[SYNC_STAGES-1].re_n;
    end
  end

  assign bus_smp = pipe_q[SYNC_STAGES-1];
  assign we_fall = we_prev_q & ~bus_smp.we_n;
  assign re_fall = re_prev_q & ~bus_smp.re_n;
endmodule

// File: rtl/nand_rd_bank.sv
`timescale 1ns/1ps
module nand_rd_bank
  import nand_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ev,
  input  logic              adr_ev,
  input  logic              rd_ev,
  input  logic              idle_ev,
  input  logic [7:0]        bus_byte,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              err
);
  localparam logic [63:0] ADDR_LIM = (64'd1 << ADDR_W) - 64'd1;

  bank_mode_e        mode_q;
  logic [1:0]        acyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ready_q;
  logic              err_q;

  logic              cmd_known;
  bank_mode_e        cmd_mode;
  logic              adr_legal;
  logic [63:0]       adr_next;

  always_comb begin
    cmd_known = 1'b1;
    cmd_mode  = mode_q;
    case (bus_byte)
      OP_IDLE:   cmd_mode  = ST_IDLE;
      OP_MODE_A: cmd_mode  = ST_MODE_A;
      OP_MODE_B: cmd_mode  = ST_MODE_B;
      OP_MODE_C: cmd_mode  = ST_MODE_C;
      default:   cmd_known = 1'b0;
    endcase
  end

  assign adr_legal = (mode_q != ST_IDLE) && (acyc_q != 2'd3);

  always_comb begin
    case (acyc_q)
      2'd0:    adr_next = sat_add(64'd0, 64'(column_base(mode_q, bus_byte)), ADDR_LIM);
      2'd1:    adr_next = sat_add(64'(addr_q), 64'(bus_byte) * 64'(ROW_HI_STRIDE), ADDR_LIM);
      default: adr_next = sat_add(64'(addr_q), 64'(bus_byte) * 64'(PAGE_BYTES), ADDR_LIM);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ST_IDLE;
      acyc_q  <= 2'd0;
      addr_q  <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cmd_ev) begin
        if (cmd_known) begin
          mode_q <= cmd_mode;
          if (cmd_mode != ST_IDLE) acyc_q <= 2'd0;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (adr_ev) begin
        if (adr_legal) begin
          addr_q <= ADDR_W'(adr_next);
          acyc_q <= acyc_q + 2'd1;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (rd_ev) addr_q <= ADDR_W'(sat_add(64'(addr_q), 64'd1, ADDR_LIM));
      if (idle_ev) ready_q <= 1'b1;
    end
  end

  assign addr  = addr_q;
  assign ready = ready_q;
  assign err   = err_q;
endmodule

// File: rtl/nand_rd_image.sv
`timescale 1ns/1ps
module nand_rd_image
  import nand_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned DEPTH      = 3 * BLOCK_BYTES,
  parameter int unsigned IMG_BLOCKS = 2,
  parameter int unsigned BANK_ID    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_byte
);
  localparam logic IS_BANK1 = (BANK_ID != 0);

  assign rd_byte = image_byte(64'(addr), IS_BANK1, 64'(DEPTH), 32'(IMG_BLOCKS));
endmodule

// File: rtl/nand_rd_responder.sv
`timescale 1ns/1ps
module nand_rd_responder
  import nand_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 26,
  parameter int unsigned DEPTH       = 3 * BLOCK_BYTES,
  parameter int unsigned IMG_BLOCKS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_in,
  input  logic       ce0_n,
  input  logic       ce1_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic [1:0] ready,
  output logic [1:0] err
);
  localparam int unsigned NUM_BANKS = 2;

  bus_snap_t bus_raw;
  bus_snap_t bus_smp;
  logic      we_fall;
  logic      re_fall;

  assign bus_raw = '{data: bus_in, ce0_n: ce0_n, ce1_n: ce1_n,
                     cle: cle, ale: ale, we_n: we_n, re_n: re_n};

  nand_rd_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_raw (bus_raw),
    .bus_smp (bus_smp),
    .we_fall (we_fall),
    .re_fall (re_fall)
  );

  // Named events, also watched by the checker.
  logic                              sel_valid;
  logic                              sel_bank;
  logic [NUM_BANKS-1:0]              cmd_ev;
  logic [NUM_BANKS-1:0]              adr_ev;
  logic [NUM_BANKS-1:0]              rd_ev;
  logic [NUM_BANKS-1:0]              idle_ev;
  logic [NUM_BANKS-1:0][ADDR_W-1:0]  bank_addr;
  logic [NUM_BANKS-1:0][7:0]         img_byte;

  assign sel_valid = ~bus_smp.ce0_n | ~bus_smp.ce1_n;
  assign sel_bank  = bus_smp.ce0_n;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = sel_valid && (sel_bank == 1'(b));
    assign cmd_ev[b]  = hit & we_fall & bus_smp.cle;
    assign adr_ev[b]  = hit & we_fall & ~bus_smp.cle & bus_smp.ale;
    assign rd_ev[b]   = hit & re_fall & ~bus_smp.cle & ~bus_smp.ale;
    assign idle_ev[b] = hit & bus_smp.we_n & bus_smp.re_n;

    nand_rd_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_ev   (cmd_ev[b]),
      .adr_ev   (adr_ev[b]),
      .rd_ev    (rd_ev[b]),
      .idle_ev  (idle_ev[b]),
      .bus_byte (bus_smp.data),
      .addr     (bank_addr[b]),
      .ready    (ready[b]),
      .err      (err[b])
    );

    nand_rd_image #(
      .ADDR_W     (ADDR_W),
      .DEPTH      (DEPTH),
      .IMG_BLOCKS (IMG_BLOCKS),
      .BANK_ID    (b)
    ) u_image (
      .addr    (bank_addr[b]),
      .rd_byte (img_byte[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out <= 8'h00;
      bus_oe  <= 1'b0;
    end else if (|rd_ev) begin
      bus_out <= rd_ev[1] ? img_byte[1] : img_byte[0];
      bus_oe  <= 1'b1;
    end else if (|idle_ev) begin
      bus_oe  <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_rd_checker.sv
`timescale 1ns/1ps
module nand_rd_checker #(
  parameter int unsigned ADDR_W = 26
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sel_valid,
  input logic [1:0]            cmd_ev,
  input logic [1:0]            adr_ev,
  input logic [1:0]            rd_ev,
  input logic [1:0]            idle_ev,
  input logic [1:0][ADDR_W-1:0] bank_addr,
  input logic [7:0]            bus_out,
  input logic                  bus_oe,
  input logic [1:0]            ready,
  input logic [1:0]            err
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_ev) |=> bus_oe);

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|idle_ev) |=> !bus_oe);

  assert_unselected_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> ($stable(bus_oe) && $stable(bus_out)));

  assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_ev | adr_ev | rd_ev | idle_ev));

  for (genvar b = 0; b < 2; b++) begin : g_bank_chk
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err[b] |=> err[b]);

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready[b] |=> ready[b]);

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev[b] && bank_addr[b] == ADDR_TOP) |=> bank_addr[b] == ADDR_TOP);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev[b] && bank_addr[b] != ADDR_TOP) |=> bank_addr[b] == $past(bank_addr[b]) + 1'b1);
  end
endmodule

bind nand_rd_responder nand_rd_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_valid (sel_valid),
  .cmd_ev    (cmd_ev),
  .adr_ev    (adr_ev),
  .rd_ev     (rd_ev),
  .idle_ev   (idle_ev),
  .bank_addr (bank_addr),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .ready     (ready),
  .err       (err)
);

// File: tb/nand_rd_responder_test.sv
`timescale 1ns/1ps
module nand_rd_responder_test;
  localparam int     AW    = 16;
  localparam longint DEPTH = 50688;
  localparam longint PRE   = 2;
  localparam longint LIM   = (longint'(1) << AW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic       ce0_n = 1'b1, ce1_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [1:0] ready, err;

  always #2.5 clk = ~clk;

  nand_rd_responder #(.ADDR_W(AW), .DEPTH(DEPTH), .IMG_BLOCKS(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_in(din), .ce0_n(ce0_n), .ce1_n(ce1_n),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready), .err(err));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model.
  typedef struct packed {logic [7:0] d; logic c0, c1, cl, al, we, re;} snap_t;
  localparam snap_t QUIET = '{d: 8'h00, c0: 1'b1, c1: 1'b1, cl: 1'b0, al: 1'b0, we: 1'b1, re: 1'b1};
  snap_t  h0 = QUIET, h1 = QUIET, h2 = QUIET;
  int     m_mode [2];
  int     m_cyc  [2];
  longint m_addr [2];
  bit     m_rdy  [2];
  bit     m_err  [2];
  bit     m_den;
  int     m_dout;

  function automatic int img(int b, longint a);
    if (a >= DEPTH) return 255;
    if (a < 4) return int'((PRE >> (8 * a)) % 256);
    if (a >= 16896 && a < 16896 * (PRE + 1))
      return int'((a % 256) ^ ((a / 256) % 256) ^ (b == 1 ? 165 : 0));
    return 255;
  endfunction

  function automatic longint clip(longint v);
    return (v > LIM) ? LIM : v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_mode[b] = 0; m_cyc[b] = 0; m_addr[b] = 0; m_rdy[b] = 0; m_err[b] = 0;
    end
    m_den = 0; m_dout = 0;
  endtask

  task automatic model_step(input snap_t cur, input snap_t prv);
    int b;
    if (cur.c0 && cur.c1) return;
    b = cur.c0 ? 1 : 0;
    if (cur.we && cur.re) begin
      m_den = 0; m_rdy[b] = 1;
    end else if (prv.we && !cur.we) begin
      if (cur.cl) begin
        case (cur.d)
          8'hFF: m_mode[b] = 0;
          8'h00: begin m_mode[b] = 1; m_cyc[b] = 0; end
          8'h01: begin m_mode[b] = 2; m_cyc[b] = 0; end
          8'h50: begin m_mode[b] = 3; m_cyc[b] = 0; end
          default: m_err[b] = 1;
        endcase
      end else if (cur.al) begin
        if (m_mode[b] == 0 || m_cyc[b] == 3) m_err[b] = 1;
        else begin
          if (m_cyc[b] == 0)      m_addr[b] = clip(cur.d + 256 * (m_mode[b] - 1));
          else if (m_cyc[b] == 1) m_addr[b] = clip(m_addr[b] + longint'(cur.d) * 135168);
          else                    m_addr[b] = clip(m_addr[b] + longint'(cur.d) * 528);
          m_cyc[b]++;
        end
      end
    end
    if (prv.re && !cur.re && !cur.cl && !cur.al) begin
      m_dout = img(b, m_addr[b]); m_den = 1; m_addr[b] = clip(m_addr[b] + 1);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset(); h0 = QUIET; h1 = QUIET; h2 = QUIET;
    end else begin
      model_step(h1, h2);
      h2 = h1; h1 = h0;
      h0 = '{d: din, c0: ce0_n, c1: ce1_n, cl: cle, al: ale, we: we_n, re: re_n};
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 bus_oe vs model", longint'(bus_oe), longint'(m_den));
      check("R8 ready vs model", longint'(ready), longint'({m_rdy[1], m_rdy[0]}));
      check("R4 err vs model", longint'(err), longint'({m_err[1], m_err[0]}));
      if (m_den) check("R9 bus_out vs model", longint'(bus_out), longint'(m_dout));
    end
  end

  task automatic wr(input bit s0, input bit s1, input bit c, input bit a, input logic [7:0] v);
    @(negedge clk); ce0_n = !s0; ce1_n = !s1; cle = c; ale = a; din = v; we_n = 1; re_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input bit s0, input bit s1, output logic [7:0] v);
    @(negedge clk); ce0_n = !s0; ce1_n = !s1; cle = 0; ale = 0; re_n = 0;
    repeat (3) @(negedge clk);
    v = bus_out;
    re_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic addr3(input bit s0, input bit s1, input logic [7:0] a0, a1, a2);
    wr(s0, s1, 0, 1, a0); wr(s0, s1, 0, 1, a1); wr(s0, s1, 0, 1, a2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    check("R11 bus_oe in reset", longint'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 bus_oe after reset", longint'(bus_oe), 0);
    check("R11 ready after reset", longint'(ready), 0);
    check("R11 err after reset", longint'(err), 0);

    // R8: idle with bank 0 selected sets only its ready bit
    @(negedge clk); ce0_n = 0;
    repeat (4) @(negedge clk);
    check("R8 ready bank0 only", longint'(ready), 1);

    // R1 R9: mode A at zero returns the block count bytes
    wr(1, 0, 1, 0, 8'h00); addr3(1, 0, 8'h00, 8'h00, 8'h00);
    rd(1, 0, v); check("R9 count byte0", longint'(v), 2);
    rd(1, 0, v); check("R1 R6 count byte1", longint'(v), 0);

    // R2 R3: mode B, column 0x110, page 32
    wr(1, 0, 1, 0, 8'h01); addr3(1, 0, 8'h10, 8'h00, 8'h20);
    rd(1, 0, v); check("R2 R3 mode B first byte", longint'(v), 'h53);
    rd(1, 0, v); check("R6 next byte", longint'(v), 'h52);

    // R2 R7: mode C on bank 1
    wr(0, 1, 1, 0, 8'h50); addr3(0, 1, 8'h03, 8'h00, 8'h20);
    rd(0, 1, v); check("R2 R7 bank1 mode C", longint'(v), 'hE2);
    check("R8 both ready", longint'(ready), 3);

    // R3 R10: row byte saturates the pointer, no wrap on read
    wr(1, 0, 1, 0, 8'h00); addr3(1, 0, 8'h00, 8'h01, 8'h00);
    rd(1, 0, v); check("R10 saturated read", longint'(v), 'hFF);
    rd(1, 0, v); check("R10 no wrap", longint'(v), 'hFF);

    // R7: unselected and priority
    wr(0, 1, 1, 0, 8'h00); addr3(0, 1, 8'h00, 8'h00, 8'h00);
    rd(0, 0, v); check("R7 unselected read ignored", longint'(bus_oe), 0);
    rd(1, 1, v); check("R7 ce0 priority", longint'(v), 'hFF);
    rd(0, 1, v); check("R7 bank1 untouched", longint'(v), 2);

    // R5: command latch wins over address latch
    wr(1, 0, 1, 1, 8'h01); addr3(1, 0, 8'h10, 8'h00, 8'h20);
    rd(1, 0, v); check("R5 cle priority", longint'(v), 'h53);
    check("R5 no error", longint'(err), 0);

    // R4: unknown command
    wr(1, 0, 1, 0, 8'h33);
    check("R4 unknown cmd err", longint'(err), 1);
    rd(1, 0, v); check("R4 state kept", longint'(v), 'h52);

    // R4: address while idle
    wr(0, 1, 1, 0, 8'hFF); wr(0, 1, 0, 1, 8'h07);
    check("R4 idle address err", longint'(err), 3);
    rd(0, 1, v); check("R4 bank1 pointer kept", longint'(v), 0);

    // R4: fourth address byte ignored
    wr(1, 0, 1, 0, 8'h00); addr3(1, 0, 8'h10, 8'h00, 8'h20); wr(1, 0, 0, 1, 8'h55);
    rd(1, 0, v); check("R4 fourth address ignored", longint'(v), 'h52);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule